// File: doc/BRIEF.md
# Reloading Down-Count Timer

A register-mapped periodic timer for a bus-clocked subsystem. Software programs a start value, and a counter counts down from that value through zero before reloading the start value and going on. Zero is a counted state, so one period lasts the start value plus one clock cycles, and software writes N-1 to get a period of N cycles.

Each arrival at zero sets a sticky expiry flag, and that flag raises a level interrupt while interrupt enable is set. The live count and the flags can be read at any time. Software can read the count next to the expiry flag and merge them into a longer timebase without missing a wrap. Both flags are cleared by writing ones to them. A second sticky flag records that the start value was rewritten while the timer was counting.

The bus is a plain single-cycle register port: word address, write strobe, write data, and a read data path that follows the address combinationally.

Top module: `period_dncount_timer`

## Requirements
- R1: While counting, the counter reaches 0 and on the next cycle reloads the start value, so the count repeats every start value + 1 cycles.
- R2: While counting, the counter goes down by exactly one per clock cycle whenever it is not at 0. Counting needs both control bit 24 (run) and control bit 26 (timer enable) set; the control register sits at byte offset 0x4.
- R3: A write to offset 0x0 stores the start value and loads it into the counter on the same clock edge, whatever the counter was doing. Offset 0x0 reads back the start value and offset 0x8 reads the live count.
- R4: While run or timer enable is low, the counter holds its value.
- R5: A cycle in which the counter is counting, sits at 0 and sees no start write sets the expiry flag, bit 24 of the status register at offset 0xC. The flag stays set until software clears it.
- R6: Status bits are cleared only by writing a one to them: a zero in the status write data leaves that bit alone. Writes to the count offset 0x8 are ignored.
- R7: When an expiry and a write that clears the expiry flag fall in the same cycle, the flag stays set.
- R8: irq_o is high exactly while the expiry flag and control bit 25 (interrupt enable) are both set. It drops in the cycle after the flag is cleared.
- R9: A start write while the timer is counting sets the reload-change flag, status bit 25. Writing a one to that bit clears it.
- R10: After reset the start value, control, count and status all read 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Level interrupt: expiry flag AND interrupt enable |

## Verification
The hardest case to reach from the ports is an expiry landing on exactly the cycle that software clears the expiry flag. With a longer period, that takes cycle-exact alignment of the clear write. The bench avoids this by programming a start value of 0, which makes every counting cycle an expiry, so any clear write lands on one. The bench then checks that the flag survives. The period check starts the counter from a stopped state, so the first decrement comes one cycle after the control write, and the bench samples the count at every step of a full wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [3:0] OFS_START = 4'h0;
  localparam logic [3:0] OFS_CTRL  = 4'h4;
  localparam logic [3:0] OFS_COUNT = 4'h8;
  localparam logic [3:0] OFS_STAT  = 4'hC;

  localparam int BIT_RUN = 24;
  localparam int BIT_IEN = 25;
  localparam int BIT_TEN = 26;
  localparam int BIT_TE  = 24;
  localparam int BIT_BE  = 25;

  typedef struct packed {
    logic ten;
    logic ien;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  start_q,
  output ctrl_t             ctrl_q,
  output logic              start_wr,
  output logic              te_clr,
  output logic              be_clr
);
  logic ctrl_wr;
  logic stat_wr;
  logic unused_wdata;

  assign start_wr = we && (addr == ADDR_W'(OFS_START));
  assign ctrl_wr  = we && (addr == ADDR_W'(OFS_CTRL));
  assign stat_wr  = we && (addr == ADDR_W'(OFS_STAT));
  assign te_clr   = stat_wr && wdata[BIT_TE];
  assign be_clr   = stat_wr && wdata[BIT_BE];
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (start_wr) start_q <= wdata[CNT_W-1:0];
      if (ctrl_wr) begin
        ctrl_q.run <= wdata[BIT_RUN];
        ctrl_q.ien <= wdata[BIT_IEN];
        ctrl_q.ten <= wdata[BIT_TEN];
      end
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] start_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  function automatic logic at_terminal(input logic [CNT_W-1:0] cur);
    return cur == '0;
  endfunction

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rld);
    return at_terminal(cur) ? rld : cur - CNT_W'(1);
  endfunction

  assign expire = enable && !load && at_terminal(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load)    cnt_q <= load_val;
    else if (enable)  cnt_q <= count_next(cnt_q, start_q);
  end
endmodule

// File: rtl/tmr_status.sv
module tmr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic be_set,
  input  logic te_clr,
  input  logic be_clr,
  output logic te_q,
  output logic be_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_q <= 1'b0;
      be_q <= 1'b0;
    end else begin
      if (expire)      te_q <= 1'b1;
      else if (te_clr) te_q <= 1'b0;
      if (be_set)      be_q <= 1'b1;
      else if (be_clr) be_q <= 1'b0;
    end
  end
endmodule

// File: rtl/period_dncount_timer.sv
module period_dncount_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_wr;
  logic             te_clr;
  logic             be_clr;
  logic             counting;
  logic             expire;
  logic             be_set;
  logic             te_q;
  logic             be_q;

  tmr_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .start_q(start_q), .ctrl_q(ctrl_q), .start_wr(start_wr),
    .te_clr(te_clr), .be_clr(be_clr)
  );

  assign counting = ctrl_q.run && ctrl_q.ten;
  assign be_set   = start_wr && counting;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(counting), .load(start_wr),
    .load_val(bus_wdata[CNT_W-1:0]), .start_q(start_q),
    .cnt_q(cnt_q), .expire(expire)
  );

  tmr_status u_sts (
    .clk(clk), .rst_n(rst_n), .expire(expire), .be_set(be_set),
    .te_clr(te_clr), .be_clr(be_clr), .te_q(te_q), .be_q(be_q)
  );

  assign irq_o = te_q && ctrl_q.ien;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_START): bus_rdata = DATA_W'(start_q);
      ADDR_W'(OFS_COUNT): bus_rdata = DATA_W'(cnt_q);
      ADDR_W'(OFS_CTRL): begin
        bus_rdata[BIT_RUN] = ctrl_q.run;
        bus_rdata[BIT_IEN] = ctrl_q.ien;
        bus_rdata[BIT_TEN] = ctrl_q.ten;
      end
      ADDR_W'(OFS_STAT): begin
        bus_rdata[BIT_TE] = te_q;
        bus_rdata[BIT_BE] = be_q;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             counting,
  input logic             start_wr,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] start_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             expire,
  input logic             te_clr,
  input logic             te_q,
  input logic             be_q,
  input logic             irq_o
);
  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    counting && cnt_q == '0 && !start_wr |=> cnt_q == $past(start_q) && te_q); // R1
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    counting && cnt_q != '0 && !start_wr |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R2
  AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> cnt_q == $past(load_val)); // R3
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !counting && !start_wr |=> $stable(cnt_q)); // R4
  AST_TE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    te_q && !te_clr |=> te_q); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    expire && te_clr |=> te_q); // R7
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    te_clr && !expire |=> !irq_o); // R8
  AST_BE_ON_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr && counting |=> be_q); // R9
endmodule

bind period_dncount_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .counting(counting), .start_wr(start_wr),
  .load_val(bus_wdata[CNT_W-1:0]), .start_q(start_q), .cnt_q(cnt_q),
  .expire(expire), .te_clr(te_clr), .te_q(te_q), .be_q(be_q), .irq_o(irq_o)
);

// File: tb/sim_period_dncount_timer.sv
module sim_period_dncount_timer;
  localparam int CLK_T = 10;
  localparam logic [3:0] A_START = 4'h0, A_CTRL = 4'h4, A_CNT = 4'h8, A_STAT = 4'hC;
  localparam logic [31:0] C_RUN = 32'h0100_0000, C_IEN = 32'h0200_0000, C_TEN = 32'h0400_0000;
  localparam logic [31:0] S_TE = 32'h0100_0000, S_BE = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  period_dncount_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_START, v); chk("R10 start", v, 0);
    rd(A_CTRL, v);  chk("R10 ctrl", v, 0);
    rd(A_CNT, v);   chk("R10 count", v, 0);
    rd(A_STAT, v);  chk("R10 status", v, 0);
    chk("R10 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    wr(A_START, 7);
    rd(A_CNT, v);   chk("R3 count loaded", v, 7);
    rd(A_START, v); chk("R3 start readback", v, 7);
    rd(A_STAT, v);  chk("R9 no flag when stopped", v, 0);
    wr(A_CTRL, C_TEN);
    edges(3);
    rd(A_CNT, v);   chk("R4 hold run low", v, 7);
    wr(A_CTRL, C_RUN);
    edges(3);
    rd(A_CNT, v);   chk("R4 hold ten low", v, 7);
  endtask

  task automatic t_period();
    logic [31:0] v;
    wr(A_CTRL, 0);
    wr(A_START, 4);
    wr(A_STAT, S_TE | S_BE);
    wr(A_CTRL, C_RUN | C_TEN | C_IEN);
    rd(A_CNT, v);  chk("R2 first cycle", v, 4);
    edges(1);
    rd(A_CNT, v);  chk("R2 step down", v, 3);
    edges(3);
    rd(A_CNT, v);  chk("R1 reaches zero", v, 0);
    rd(A_STAT, v); chk("R5 not yet set", v, 0);
    chk("R8 irq low before expiry", {31'b0, irq_o}, 0);
    edges(1);
    rd(A_CNT, v);  chk("R1 reload", v, 4);
    rd(A_STAT, v); chk("R5 expiry set", v, S_TE);
    chk("R8 irq high", {31'b0, irq_o}, 1);
    edges(5);
    rd(A_CNT, v);  chk("R1 period start+1", v, 4);
    rd(A_STAT, v); chk("R5 sticky", v, S_TE);
  endtask

  task automatic t_w1c();
    logic [31:0] v, c0;
    wr(A_CTRL, C_IEN);
    rd(A_CNT, c0);
    wr(A_STAT, 0);
    rd(A_STAT, v); chk("R6 zero write keeps flag", v, S_TE);
    wr(A_CNT, 32'h0000_0123);
    rd(A_CNT, v);  chk("R6 count write ignored", v, c0);
    chk("R8 irq before clear", {31'b0, irq_o}, 1);
    wr(A_STAT, S_TE);
    rd(A_STAT, v); chk("R5 cleared by one", v, 0);
    chk("R8 irq drops", {31'b0, irq_o}, 0);
  endtask

  task automatic t_be();
    logic [31:0] v;
    wr(A_CTRL, C_RUN | C_TEN);
    wr(A_START, 9);
    rd(A_STAT, v); chk("R9 rewrite while counting", v, S_BE);
    edges(10);
    rd(A_CNT, v);  chk("R1 reload after rewrite", v, 9);
    rd(A_STAT, v); chk("R5 expiry with flag", v, S_TE | S_BE);
    chk("R8 irq masked by ien", {31'b0, irq_o}, 0);
    wr(A_STAT, S_BE);
    rd(A_STAT, v); chk("R9 cleared, R6 TE kept", v, S_TE);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    wr(A_CTRL, 0);
    wr(A_START, 0);
    wr(A_STAT, S_TE | S_BE);
    wr(A_CTRL, C_RUN | C_TEN);
    edges(2);
    rd(A_STAT, v); chk("R5 zero start expires", v, S_TE);
    wr(A_STAT, S_TE);
    rd(A_STAT, v); chk("R7 set wins over clear", v, S_TE);
    wr(A_CTRL, 0);
    wr(A_STAT, S_TE);
    rd(A_STAT, v); chk("R7 clear when idle", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold();
    t_period();
    t_w1c();
    t_be();
    t_prio();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule